// File: doc/BRIEF.md
# Timer-Triggered Pulse Output Port

This block drives an 8-bit output port whose bits change only on trigger events. Software writes the next pattern into a data register ahead of time. A trigger then copies the relevant bits of that register into the output latches, so the new pattern appears on a timing edge and not at the moment of the write. The port is split into a low group and a high group, and each group has its own trigger. The default trigger for each group is an underflow strobe from its own timer. The low group can instead be triggered by an external pin, on the falling edge, the rising edge, or both.

A global polarity bit can invert the whole port. Each of the three lowest bits can also be gated by a pulse-width-modulated pulse, chosen from three external pulse sources. Each group has a clear bit that holds its latches at zero. A 3-bit enable field switches the whole port on or off. The timers, the PWM generators and the pin multiplexing are outside this block.

Top module: `trig_pulse_port`

## Requirements
- R1: After reset, `port_out` is 0 and every register reads as zero. The registers are MODE (`wr_addr` 0), DATA (`wr_addr` 1) and CTRL (`wr_addr` 2). A write to `wr_addr` 3 has no effect, and any write takes effect at the clock edge where `wr_en` is sampled high.
- R2: The port is enabled when MODE[2:0] is nonzero. While it is disabled, `port_out` is 0 and triggers leave the latches unchanged. The held latch values reappear once the port is enabled again.
- R3: With CTRL[7:6] = 00, a `tmr_lo_uf` pulse loads DATA into the low-group latches and a `tmr_hi_uf` pulse loads DATA into the high-group latches. In each case the latches are updated at that clock edge, and the bits of the other group keep their values.
- R4: MODE[3] sets the split between the groups. With MODE[3] = 0 the low group is bits 3..0 and the high group is bits 7..4. With MODE[3] = 1 the low group is bits 5..0 and the high group is bits 7..6.
- R5: CTRL[7:6] selects the trigger for the low group. 00 means the timer strobe, 01 means a falling edge on `ext_trig`, 10 means a rising edge and 11 means either edge. When the code is nonzero, `tmr_lo_uf` has no effect.
- R6: `ext_trig` passes through two synchronizer flops before edge detection. A change that is sampled at clock edge k loads the low group at edge k+2.
- R7: When CTRL[3] is 0 each output equals its latch. When CTRL[3] is 1 each output is the inverse of its latch, provided the port is enabled.
- R8: While MODE[6] is 1 the low-group latches are cleared on every clock edge, and while MODE[7] is 1 the high-group latches are cleared. A clear takes priority over a trigger in the same cycle.
- R9: When CTRL[i] is 1 (i = 0..2), output bit i is its latch ANDed with the selected PWM pulse, and polarity is applied afterwards. MODE[5:4] selects the pulse: 00 picks `pwm_src[0]`, 01 picks `pwm_src[1]`, 10 picks `pwm_src[2]` and 11 gives a constant-low pulse.
- R10: If a DATA write and a trigger occur in the same cycle, the latches take the DATA value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| tmr_lo_uf | input | 1 | Underflow strobe of the low-group timer |
| tmr_hi_uf | input | 1 | Underflow strobe of the high-group timer |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| pwm_src | input | 3 | PWM pulses from three timers |
| port_out | output | 8 | Pulse output port |

## Verification
Most internal state of this block reaches `port_out` in the same cycle: a wrong latch bit, a misrouted group mask or a swapped polarity shows up on the next negative edge after the faulty clock edge. Some faults stay hidden until the port is enabled or a group is triggered, so the reference model is compared on every cycle. These include a wrong synchronizer depth, a wrong edge decode, or a trigger that slipped through while the port was disabled. The stimulus includes disabled periods, clears and trigger-select changes. The edge-detector fault is exposed two cycles after the pin toggles. The disabled-trigger fault is exposed when the port is enabled again.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

  localparam int PORT_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int PWM_BITS  = 3;
  localparam int PWM_SRCS  = 3;
  localparam int LO_NARROW = 4;
  localparam int LO_WIDE   = 6;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  typedef enum logic [1:0] {
    TRG_TIMER = 2'b00,
    TRG_FALL  = 2'b01,
    TRG_RISE  = 2'b10,
    TRG_BOTH  = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic       clr_hi;
    logic       clr_lo;
    logic [1:0] pwm_sel;
    logic       split;
    logic [2:0] out_sel;
  } mode_reg_t;

  typedef struct packed {
    trig_mode_e          trig;
    logic [1:0]          rsvd;
    logic                pol;
    logic [PWM_BITS-1:0] pwm_en;
  } ctrl_reg_t;

  // Mask of the bits that belong to the low trigger group.
  function automatic logic [PORT_W-1:0] low_mask(input logic split);
    logic [PORT_W-1:0] m;
    m = '0;
    for (int i = 0; i < PORT_W; i++) begin
      m[i] = split ? (i < LO_WIDE) : (i < LO_NARROW);
    end
    return m;
  endfunction

  // Does the pin transition match the selected edge?
  function automatic logic edge_match(input trig_mode_e md, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (md)
      TRG_FALL: return fall;
      TRG_RISE: return rise;
      TRG_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  // PWM pulse picked by the select code; code 3 yields a constant low.
  function automatic logic pwm_pick(input logic [1:0] sel, input logic [PWM_SRCS-1:0] src);
    case (sel)
      2'd0:    return src[0];
      2'd1:    return src[1];
      2'd2:    return src[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tpp_regs.sv
module tpp_regs
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  output mode_reg_t         mode_q,
  output ctrl_reg_t         ctrl_q,
  output logic [PORT_W-1:0] data_q
);

  logic wr_mode, wr_data_reg, wr_ctrl;

  assign wr_mode     = wr_en && (wr_addr == A_MODE);
  assign wr_data_reg = wr_en && (wr_addr == A_DATA);
  assign wr_ctrl     = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_reg_t'(wr_data);
      if (wr_data_reg) data_q <= wr_data;
      if (wr_ctrl) begin
        ctrl_q.trig   <= trig_mode_e'(wr_data[7:6]);
        ctrl_q.rsvd   <= 2'b00;
        ctrl_q.pol    <= wr_data[3];
        ctrl_q.pwm_en <= wr_data[PWM_BITS-1:0];
      end
    end
  end

endmodule

// File: rtl/tpp_edge_sync.sv
module tpp_edge_sync
  import tpp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  trig_mode_e md,
  output logic       strobe
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              cur;

  assign cur = chain[STAGES-1];

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign strobe = (md != TRG_TIMER) && edge_match(md, cur, prev);

endmodule

// File: rtl/tpp_latch_bank.sv
module tpp_latch_bank
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] data,
  input  logic [PORT_W-1:0] lo_mask,
  input  logic              lo_fire,
  input  logic              hi_fire,
  input  logic              clr_lo,
  input  logic              clr_hi,
  output logic [PORT_W-1:0] lat_q
);

  genvar gi;
  generate
    for (gi = 0; gi < PORT_W; gi++) begin : g_bit
      logic clr_b, fire_b;
      assign clr_b  = lo_mask[gi] ? clr_lo  : clr_hi;
      assign fire_b = lo_mask[gi] ? lo_fire : hi_fire;
      always_ff @(posedge clk) begin
        if (!rst_n)      lat_q[gi] <= 1'b0;
        else if (clr_b)  lat_q[gi] <= 1'b0;
        else if (fire_b) lat_q[gi] <= data[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/tpp_out_stage.sv
module tpp_out_stage
  import tpp_pkg::*;
(
  input  logic                lat_en,
  input  logic [PORT_W-1:0]   lat_q,
  input  logic                pol,
  input  logic [PWM_BITS-1:0] pwm_en,
  input  logic [1:0]          pwm_sel,
  input  logic [PWM_SRCS-1:0] pwm_src,
  output logic [PORT_W-1:0]   port_out
);

  logic pulse;
  assign pulse = pwm_pick(pwm_sel, pwm_src);

  genvar gi;
  generate
    for (gi = 0; gi < PORT_W; gi++) begin : g_bit
      logic gated;
      if (gi < PWM_BITS) begin : g_pwm
        assign gated = pwm_en[gi] ? (lat_q[gi] & pulse) : lat_q[gi];
      end else begin : g_plain
        assign gated = lat_q[gi];
      end
      assign port_out[gi] = lat_en & (gated ^ pol);
    end
  endgenerate

endmodule

// File: rtl/trig_pulse_port.sv
module trig_pulse_port
  import tpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [tpp_pkg::ADDR_W-1:0]   wr_addr,
  input  logic [tpp_pkg::PORT_W-1:0]   wr_data,
  input  logic                      tmr_lo_uf,
  input  logic                      tmr_hi_uf,
  input  logic                      ext_trig,
  input  logic [tpp_pkg::PWM_SRCS-1:0] pwm_src,
  output logic [tpp_pkg::PORT_W-1:0]   port_out
);

  mode_reg_t         mode_q;
  ctrl_reg_t         ctrl_q;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] lat_q;
  logic [PORT_W-1:0] lo_mask_w;
  logic              port_en_w;
  logic              ext_strobe_w;
  logic              lo_fire_w;
  logic              hi_fire_w;

  tpp_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .ctrl_q  (ctrl_q),
    .data_q  (data_q)
  );

  tpp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (ext_trig),
    .md     (ctrl_q.trig),
    .strobe (ext_strobe_w)
  );

  assign port_en_w = (mode_q.out_sel != 3'b000);
  assign lo_mask_w = low_mask(mode_q.split);
  assign lo_fire_w = port_en_w && ((ctrl_q.trig == TRG_TIMER) ? tmr_lo_uf : ext_strobe_w);
  assign hi_fire_w = port_en_w && tmr_hi_uf;

  tpp_latch_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .data    (data_q),
    .lo_mask (lo_mask_w),
    .lo_fire (lo_fire_w),
    .hi_fire (hi_fire_w),
    .clr_lo  (mode_q.clr_lo),
    .clr_hi  (mode_q.clr_hi),
    .lat_q   (lat_q)
  );

  tpp_out_stage u_out (
    .lat_en   (port_en_w),
    .lat_q    (lat_q),
    .pol      (ctrl_q.pol),
    .pwm_en   (ctrl_q.pwm_en),
    .pwm_sel  (mode_q.pwm_sel),
    .pwm_src  (pwm_src),
    .port_out (port_out)
  );

endmodule

// File: rtl/tpp_checker.sv
module tpp_checker
  import tpp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input mode_reg_t         mode_q,
  input ctrl_reg_t         ctrl_q,
  input logic [PORT_W-1:0] data_q,
  input logic [PORT_W-1:0] lat_q,
  input logic [PORT_W-1:0] lo_mask_w,
  input logic              port_en_w,
  input logic              ext_strobe_w,
  input logic              lo_fire_w,
  input logic              hi_fire_w,
  input logic [PORT_W-1:0] port_out
);

  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_w |-> port_out == '0); // R2

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_w |-> !(lo_fire_w || hi_fire_w)); // R2

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_fire_w && !mode_q.clr_lo) |=> ((lat_q & $past(lo_mask_w)) == ($past(data_q) & $past(lo_mask_w)))); // R3

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_fire_w && !mode_q.clr_hi) |=> (((lat_q ^ $past(lat_q)) & ~$past(lo_mask_w)) == '0)); // R3

  AST_TIMER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.trig != TRG_TIMER && !ext_strobe_w) |-> !lo_fire_w); // R5

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe_w |-> ctrl_q.trig != TRG_TIMER); // R5

  AST_CLR_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.clr_lo |=> (lat_q & $past(lo_mask_w)) == '0); // R8

  AST_CLR_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.clr_hi |=> (lat_q & ~$past(lo_mask_w)) == '0); // R8

endmodule

bind trig_pulse_port tpp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .ctrl_q       (ctrl_q),
  .data_q       (data_q),
  .lat_q        (lat_q),
  .lo_mask_w    (lo_mask_w),
  .port_en_w    (port_en_w),
  .ext_strobe_w (ext_strobe_w),
  .lo_fire_w    (lo_fire_w),
  .hi_fire_w    (hi_fire_w),
  .port_out     (port_out)
);

// File: tb/trig_pulse_port_tb.sv
module trig_pulse_port_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tmr_lo_uf = 1'b0;
  logic       tmr_hi_uf = 1'b0;
  logic       ext_trig = 1'b0;
  logic [2:0] pwm_src = '0;
  logic [7:0] port_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_pulse_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tmr_lo_uf (tmr_lo_uf),
    .tmr_hi_uf (tmr_hi_uf),
    .ext_trig  (ext_trig),
    .pwm_src   (pwm_src),
    .port_out  (port_out)
  );

  // Behavioural reference state
  bit [7:0] m_mode, m_ctrl, m_data, m_lat;
  bit       s_pin [$];   // synchronizer queue, oldest first
  bit       m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ctrl = 0; m_data = 0; m_lat = 0;
      s_pin = '{0, 0}; m_prev = 0;
    end else begin
      bit cur, hit, en, lo_go, hi_go;
      int nlo;
      cur = s_pin[0];
      case (m_ctrl[7:6])
        2'b01:   hit = (!cur && m_prev);
        2'b10:   hit = (cur && !m_prev);
        2'b11:   hit = (cur != m_prev);
        default: hit = 0;
      endcase
      en    = (m_mode[2:0] != 0);
      lo_go = en && ((m_ctrl[7:6] == 0) ? tmr_lo_uf : hit);
      hi_go = en && tmr_hi_uf;
      nlo   = m_mode[3] ? 6 : 4;
      for (int i = 0; i < 8; i++) begin
        if (i < nlo) begin
          if (m_mode[6]) m_lat[i] = 0;
          else if (lo_go) m_lat[i] = m_data[i];
        end else begin
          if (m_mode[7]) m_lat[i] = 0;
          else if (hi_go) m_lat[i] = m_data[i];
        end
      end
      m_prev = cur;
      void'(s_pin.pop_front());
      s_pin.push_back(ext_trig);
      if (wr_en) begin
        if (wr_addr == 0) m_mode = wr_data;
        if (wr_addr == 1) m_data = wr_data;
        if (wr_addr == 2) m_ctrl = {wr_data[7:6], 2'b00, wr_data[3:0]};
      end
    end
  end

  function automatic bit [7:0] model_out();
    bit [7:0] o;
    bit pulse;
    if (m_mode[2:0] == 0) return 8'h00;
    case (m_mode[5:4])
      2'd0: pulse = pwm_src[0];
      2'd1: pulse = pwm_src[1];
      2'd2: pulse = pwm_src[2];
      default: pulse = 0;
    endcase
    for (int i = 0; i < 8; i++) begin
      o[i] = m_lat[i];
      if (i < 3 && m_ctrl[i]) o[i] = o[i] & pulse;
      o[i] = o[i] ^ m_ctrl[3];
    end
    return o;
  endfunction

  task automatic compare();
    bit [7:0] exp_v;
    exp_v = model_out();
    n_cmp++;
    if (port_out !== exp_v) begin
      n_bad++;
      $display("FAIL %s: port_out=%h expected %h at %0t", tag, port_out, exp_v, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_lo();
    tmr_lo_uf = 1; tick(); tmr_lo_uf = 0;
  endtask

  task automatic pulse_hi();
    tmr_hi_uf = 1; tick(); tmr_hi_uf = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    n_cmp++;
    if (port_out !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: port_out=%h expected 00 after reset", port_out);
    end
    wr(2'd3, 8'hFF); idle(2);

    tag = "R3";
    wr(2'd0, 8'h01); wr(2'd1, 8'hA5);
    pulse_lo(); idle(1); pulse_hi(); idle(1);
    wr(2'd1, 8'h5A); pulse_hi(); pulse_lo(); idle(1);

    tag = "R4";
    wr(2'd0, 8'h09); wr(2'd1, 8'h3C); pulse_lo(); idle(1);
    wr(2'd1, 8'hC3); pulse_hi(); pulse_lo(); idle(1);

    tag = "R2";
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
    pulse_lo(); pulse_hi(); idle(1);
    wr(2'd0, 8'h01); idle(2);

    tag = "R7";
    wr(2'd2, 8'h08); idle(1); pulse_lo(); idle(1);
    wr(2'd2, 8'h00); idle(1);

    tag = "R8";
    wr(2'd1, 8'hFF); pulse_lo(); pulse_hi();
    wr(2'd0, 8'h41); pulse_lo(); idle(1);
    wr(2'd0, 8'h81); pulse_hi(); idle(1);
    wr(2'd0, 8'h01); pulse_lo(); pulse_hi(); idle(1);

    tag = "R5";
    wr(2'd1, 8'h0F); wr(2'd2, 8'h40);
    wr(2'd0, 8'h41); wr(2'd0, 8'h01);
    pulse_lo(); idle(2);
    ext_trig = 1; idle(4);
    ext_trig = 0; idle(4);
    wr(2'd1, 8'h00); wr(2'd2, 8'h80);
    ext_trig = 1; idle(4);
    wr(2'd1, 8'h05);
    ext_trig = 0; idle(4);
    ext_trig = 1; idle(4);
    tag = "R6";
    wr(2'd2, 8'hC0); wr(2'd1, 8'h0A);
    ext_trig = 0; tick(); tick(); tick();
    wr(2'd1, 8'h03);
    ext_trig = 1; tick(); tick(); tick();
    ext_trig = 0; tick(); ext_trig = 1; tick(); ext_trig = 0; idle(4);

    tag = "R9";
    wr(2'd2, 8'h07); wr(2'd0, 8'h01); wr(2'd1, 8'hFF); pulse_lo();
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'(1 + (s << 4)));
      for (int p = 0; p < 8; p++) begin
        pwm_src = 3'(p);
        tick();
      end
    end
    wr(2'd2, 8'h0D);
    for (int p = 0; p < 8; p++) begin pwm_src = 3'(p); tick(); end
    wr(2'd2, 8'h00);

    tag = "R10";
    wr(2'd1, 8'h11); pulse_lo();
    wr_en = 1; wr_addr = 2'd1; wr_data = 8'hEE; tmr_lo_uf = 1; tmr_hi_uf = 1;
    tick();
    wr_en = 0; tmr_lo_uf = 0; tmr_hi_uf = 0;
    idle(1); pulse_lo(); idle(1);

    tag = "R3 mixed";
    for (int i = 0; i < 600; i++) begin
      tmr_lo_uf = 1'($urandom_range(0, 3) == 0);
      tmr_hi_uf = 1'($urandom_range(0, 3) == 0);
      ext_trig  = 1'($urandom_range(0, 1));
      pwm_src   = 3'($urandom_range(0, 7));
      wr_en     = 1'($urandom_range(0, 5) == 0);
      wr_addr   = 2'($urandom_range(0, 3));
      wr_data   = 8'($urandom_range(0, 255));
      if (wr_addr == 2'd0) wr_data[6] = wr_data[6] & wr_data[0];
      tick();
    end
    wr_en = 0; tmr_lo_uf = 0; tmr_hi_uf = 0;
    idle(3);
    summary();
  end

endmodule